// File: doc/BRIEF.md
# Split-Transaction Request Timeout Tracker

This block sits between a host-side request source and an outbound packet link, and keeps track of every request that has been sent but not yet answered. It owns a pool of request streams; each stream holds one full packet payload and a private response timer. A request offered by the host is parked in the lowest-numbered idle stream and queued for transmission. The stream's tag travels with the packet, and the link side later returns echoes and responses carrying that same tag.

An echo either accepts the packet, so it can no longer be resent and only the response is awaited, or rejects it, so the stored packet is sent again and its timer starts over. A response arriving in time completes the stream and releases it. If no response arrives before the shared, programmable timeout, the stream is released and a sticky per-stream error bit is raised. Completions may arrive in any order. Echoes or responses that name an idle stream are dropped and counted.

Top module: `req_timeout_tracker`

## Requirements
- R1: After reset all streams are idle: `req_ready` is 1, `tx_valid` is 0, `irq_status` is all zeros, `stray_count` is 0 and `done_valid` is 0.
- R2: An accepted request (`req_valid` and `req_ready` at a clock edge) is stored in the lowest-numbered idle stream. From the next cycle it is offered on `tx_valid` with `tx_tag` equal to the stream index and `tx_data` equal to the stored payload. When several streams wait to be sent, the lowest index is offered first. A stream departs at an edge where `tx_valid` and `tx_ready` are both 1.
- R3: `req_ready` is 0 exactly while every stream is busy, and returns to 1 in the cycle after any stream is released.
- R4: A response (`rsp_valid`, `rsp_tag`) for a stream that departed at edge k, sampled at edge k+j with 1 ≤ j ≤ `cfg_timeout`, releases the stream and drives `done_valid`=1 and `done_tag` equal to the stream index for the one cycle after that edge.
- R5: A stream that departed at edge k and has no response by edge k+`cfg_timeout` is released at that edge, and bit [stream index] of `irq_status` reads 1 from that edge on.
- R6: An echo with `echo_accept`=0 for a sent stream that has not been accepted puts the same payload and tag back on the transmit side. The timeout window is measured again from the new departure edge.
- R7: An echo with `echo_accept`=1 marks the stream accepted. Later rejecting echoes for it cause no retransmission, and its response is still awaited.
- R8: An echo or response whose tag names an idle stream changes no stream. Each such packet adds 1 to `stray_count`, so both in one cycle add 2. The count saturates at its all-ones value.
- R9: `irq_status` bits stay set until a cycle with `irq_clr_we`=1 clears those bits that are 1 in `irq_clr_mask`. A timeout in the same cycle as a clear of its bit leaves that bit set.
- R10: Responses may arrive for waiting streams in any order. Each one completes its own stream regardless of departure order.
- R11: A response sampled at the very edge on which its stream would time out completes the stream, and no error bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timeout | input | TMR_W (16) | Response timeout in cycles, shared by all streams, at least 1 |
| req_valid | input | 1 | Host offers a request packet |
| req_ready | output | 1 | At least one stream is idle |
| req_data | input | PKT_BYTES*8 (1024) | Request packet payload |
| tx_valid | output | 1 | A stored packet is offered to the link |
| tx_ready | input | 1 | Link takes the offered packet |
| tx_tag | output | TAG_W (4) | Stream index of the offered packet |
| tx_data | output | PKT_BYTES*8 (1024) | Payload of the offered packet |
| echo_valid | input | 1 | Echo packet present |
| echo_tag | input | TAG_W (4) | Stream index named by the echo |
| echo_accept | input | 1 | 1 = packet accepted, 0 = rejected |
| rsp_valid | input | 1 | Response packet present |
| rsp_tag | input | TAG_W (4) | Stream index named by the response |
| done_valid | output | 1 | A stream completed at the previous edge |
| done_tag | output | TAG_W (4) | Index of the completed stream |
| irq_status | output | NSTR (16) | Sticky per-stream timeout flags |
| irq_clr_we | input | 1 | Write strobe for clearing flags |
| irq_clr_mask | input | NSTR (16) | Write-one-to-clear mask |
| stray_count | output | CNT_W (8) | Saturating count of dropped echoes and responses |

## Verification
Every result is registered once: an input sampled at edge k shows on `req_ready`, `tx_*`, `done_*`, `irq_status` and `stray_count` in the cycle after k. A new request therefore reaches `tx_valid` one cycle after acceptance. A timeout flag appears `cfg_timeout` edges after the departure edge, and a retransmission appears one cycle after the rejecting echo. The bench drives inputs and reads outputs on the falling edge, between those rising edges. A behavioural model steps on each rising edge and is compared against every output on each falling edge. Directed checks are placed on the exact falling edge where a timeout, completion or resend is due, together with the cycle just before it.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;
   typedef enum logic [1:0] {
      STRM_IDLE = 2'd0,
      STRM_SEND = 2'd1,
      STRM_WAIT = 2'd2
   } strm_state_e;
endpackage

// File: rtl/rt_lowest_pick.sv
module rt_lowest_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  oh_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rt_lowest_pick: N must be at least 1");
      end
   endgenerate

   always_comb begin
      oh_o  = '0;
      idx_o = '0;
      any_o = |req_i;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            oh_o    = '0;
            oh_o[i] = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/rt_stream.sv
module rt_stream
   import req_tracker_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int DATA_W = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMR_W-1:0]  cfg_timeout,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              grant_i,
   input  logic              echo_hit_i,
   input  logic              echo_ok_i,
   input  logic              rsp_hit_i,
   output logic              idle_o,
   output logic              send_o,
   output logic [DATA_W-1:0] data_o,
   output logic              expire_o,
   output logic              deliver_o
);
   generate
      if (TMR_W < 2) begin : g_bad_tmr
         $error("rt_stream: TMR_W must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("rt_stream: DATA_W must be at least 8");
      end
   endgenerate

   strm_state_e      st_q;
   logic [TMR_W-1:0] tmr_q;
   logic             acked_q;
   logic [DATA_W-1:0] buf_q;
   logic             waiting;
   logic             at_limit;

   assign waiting   = (st_q == STRM_WAIT);
   assign at_limit  = ({1'b0, tmr_q} + {{TMR_W{1'b0}}, 1'b1}) >= {1'b0, cfg_timeout};
   assign deliver_o = waiting && rsp_hit_i;
   assign expire_o  = waiting && !rsp_hit_i && at_limit;
   assign idle_o    = (st_q == STRM_IDLE);
   assign send_o    = (st_q == STRM_SEND);
   assign data_o    = buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= STRM_IDLE;
         tmr_q   <= '0;
         acked_q <= 1'b0;
      end else begin
         unique case (st_q)
            STRM_IDLE: begin
               if (load_i) st_q <= STRM_SEND;
            end
            STRM_SEND: begin
               if (grant_i) begin
                  st_q    <= STRM_WAIT;
                  tmr_q   <= '0;
                  acked_q <= 1'b0;
               end
            end
            STRM_WAIT: begin
               if (deliver_o || expire_o) begin
                  st_q <= STRM_IDLE;
               end else if (echo_hit_i && !echo_ok_i && !acked_q) begin
                  st_q <= STRM_SEND;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
                  if (echo_hit_i && echo_ok_i) acked_q <= 1'b1;
               end
            end
            default: st_q <= STRM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (load_i) buf_q <= load_data_i;
   end

   assert_load_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (st_q == STRM_IDLE));

   assert_reject_resends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && echo_hit_i && !echo_ok_i && !acked_q && !rsp_hit_i && !at_limit)
      |=> send_o);

   assert_accepted_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && acked_q && !rsp_hit_i && !at_limit) |=> (st_q == STRM_WAIT));

   assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && cfg_timeout != '0 && $stable(cfg_timeout))
      |-> ({1'b0, tmr_q} < {1'b0, cfg_timeout}));
endmodule

// File: rtl/req_timeout_tracker.sv
module req_timeout_tracker
   import req_tracker_pkg::*;
#(
   parameter int NSTR      = 16,
   parameter int PKT_BYTES = 128,
   parameter int TMR_W     = 16,
   parameter int CNT_W     = 8,
   localparam int TAG_W    = (NSTR > 1) ? $clog2(NSTR) : 1,
   localparam int DATA_W   = PKT_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMR_W-1:0]  cfg_timeout,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DATA_W-1:0] req_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [TAG_W-1:0]  tx_tag,
   output logic [DATA_W-1:0] tx_data,
   input  logic              echo_valid,
   input  logic [TAG_W-1:0]  echo_tag,
   input  logic              echo_accept,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   output logic              done_valid,
   output logic [TAG_W-1:0]  done_tag,
   output logic [NSTR-1:0]   irq_status,
   input  logic              irq_clr_we,
   input  logic [NSTR-1:0]   irq_clr_mask,
   output logic [CNT_W-1:0]  stray_count
);
   generate
      if (NSTR < 2) begin : g_bad_nstr
         $error("req_timeout_tracker: NSTR must be at least 2");
      end
      if (NSTR != (1 << TAG_W)) begin : g_bad_pow2
         $error("req_timeout_tracker: NSTR must be a power of two");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("req_timeout_tracker: CNT_W must be at least 2");
      end
   endgenerate

   logic [NSTR-1:0]   idle_vec, send_vec, expire_vec, deliver_vec;
   logic [NSTR-1:0]   alloc_oh, tx_oh, done_oh;
   logic [NSTR-1:0]   load_vec, grant_vec, echo_hit_vec, rsp_hit_vec;
   logic [DATA_W-1:0] slot_data [NSTR];
   logic [TAG_W-1:0]  alloc_idx, done_idx;
   logic              any_done;
   logic              stray_echo, stray_rsp;
   logic [1:0]        stray_inc;
   logic [CNT_W:0]    stray_sum;
   logic [NSTR-1:0]   irq_q;
   logic [CNT_W-1:0]  stray_q;
   logic              done_v_q;
   logic [TAG_W-1:0]  done_t_q;

   rt_lowest_pick #(.N(NSTR)) u_alloc_pick (
      .req_i(idle_vec), .oh_o(alloc_oh), .idx_o(alloc_idx), .any_o(req_ready));

   rt_lowest_pick #(.N(NSTR)) u_tx_pick (
      .req_i(send_vec), .oh_o(tx_oh), .idx_o(tx_tag), .any_o(tx_valid));

   rt_lowest_pick #(.N(NSTR)) u_done_pick (
      .req_i(deliver_vec), .oh_o(done_oh), .idx_o(done_idx), .any_o(any_done));

   genvar gi;
   generate
      for (gi = 0; gi < NSTR; gi++) begin : g_strm
         assign load_vec[gi]     = req_valid && req_ready && alloc_oh[gi];
         assign grant_vec[gi]    = tx_valid && tx_ready && tx_oh[gi];
         assign echo_hit_vec[gi] = echo_valid && (echo_tag == TAG_W'(gi));
         assign rsp_hit_vec[gi]  = rsp_valid && (rsp_tag == TAG_W'(gi));

         rt_stream #(.TMR_W(TMR_W), .DATA_W(DATA_W)) u_strm (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_timeout (cfg_timeout),
            .load_i      (load_vec[gi]),
            .load_data_i (req_data),
            .grant_i     (grant_vec[gi]),
            .echo_hit_i  (echo_hit_vec[gi]),
            .echo_ok_i   (echo_accept),
            .rsp_hit_i   (rsp_hit_vec[gi]),
            .idle_o      (idle_vec[gi]),
            .send_o      (send_vec[gi]),
            .data_o      (slot_data[gi]),
            .expire_o    (expire_vec[gi]),
            .deliver_o   (deliver_vec[gi])
         );

         assert_timeout_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
            expire_vec[gi] |=> irq_status[gi]);
      end
   endgenerate

   assign tx_data = slot_data[tx_tag];

   // Stray packets: echo or response naming an idle stream
   assign stray_echo = echo_valid && idle_vec[echo_tag];
   assign stray_rsp  = rsp_valid && idle_vec[rsp_tag];
   assign stray_inc  = {1'b0, stray_echo} + {1'b0, stray_rsp};
   assign stray_sum  = {1'b0, stray_q} + {{(CNT_W-1){1'b0}}, stray_inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q    <= '0;
         stray_q  <= '0;
         done_v_q <= 1'b0;
         done_t_q <= '0;
      end else begin
         irq_q    <= (irq_q & ~(irq_clr_we ? irq_clr_mask : '0)) | expire_vec;
         stray_q  <= stray_sum[CNT_W] ? {CNT_W{1'b1}} : stray_sum[CNT_W-1:0];
         done_v_q <= any_done;
         if (any_done) done_t_q <= done_idx;
      end
   end

   assign irq_status  = irq_q;
   assign stray_count = stray_q;
   assign done_valid  = done_v_q;
   assign done_tag    = done_t_q;

   assert_offer_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !idle_vec[tx_tag]);

   assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_vec == '0) |-> !req_ready);

   assert_done_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> idle_vec[done_tag]);

   assert_stray_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stray_count >= $past(stray_count));

   assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(deliver_vec));
endmodule

// File: tb/req_timeout_tracker_tb.sv
module req_timeout_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 16;
   localparam int PB = 128;
   localparam int DW = PB * 8;
   localparam int TW = 16;
   localparam int CW = 4;
   localparam int TG = 4;
   localparam int TOUT = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] cfg_timeout = TW'(TOUT);
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [DW-1:0] req_data = '0;
   logic          tx_valid;
   logic          tx_ready = 1'b1;
   logic [TG-1:0] tx_tag;
   logic [DW-1:0] tx_data;
   logic          echo_valid = 1'b0;
   logic [TG-1:0] echo_tag = '0;
   logic          echo_accept = 1'b0;
   logic          rsp_valid = 1'b0;
   logic [TG-1:0] rsp_tag = '0;
   logic          done_valid;
   logic [TG-1:0] done_tag;
   logic [NS-1:0] irq_status;
   logic          irq_clr_we = 1'b0;
   logic [NS-1:0] irq_clr_mask = '0;
   logic [CW-1:0] stray_count;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   req_timeout_tracker #(.NSTR(NS), .PKT_BYTES(PB), .TMR_W(TW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
      .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_tag(tx_tag), .tx_data(tx_data),
      .echo_valid(echo_valid), .echo_tag(echo_tag), .echo_accept(echo_accept),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
      .done_valid(done_valid), .done_tag(done_tag),
      .irq_status(irq_status), .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
      .stray_count(stray_count));

   function automatic logic [DW-1:0] mk(input int n);
      return {32{32'hC0DE0000 + 32'(n)}};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 idle, 1 waiting to send, 2 waiting for response
   int            m_st  [NS];
   int            m_cnt [NS];
   bit            m_ack [NS];
   logic [DW-1:0] m_dat [NS];
   logic [NS-1:0] m_irq;
   int            m_stray;
   bit            m_dv;
   int            m_dt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_ack[i] = 0; m_dat[i] = '0;
         end
         m_irq = '0; m_stray = 0; m_dv = 0; m_dt = 0;
      end else begin
         int f, p;
         logic [NS-1:0] setm;
         f = -1; p = -1; setm = '0;
         for (int i = NS - 1; i >= 0; i--) begin
            if (m_st[i] == 0) f = i;
            if (m_st[i] == 1) p = i;
         end
         m_dv = 0;
         if (echo_valid && m_st[echo_tag] == 0) m_stray++;
         if (rsp_valid && m_st[rsp_tag] == 0) m_stray++;
         if (m_stray > (1 << CW) - 1) m_stray = (1 << CW) - 1;
         for (int i = 0; i < NS; i++) begin
            if (m_st[i] == 2) begin
               if (rsp_valid && rsp_tag == TG'(i)) begin
                  m_st[i] = 0; m_dv = 1; m_dt = i;
               end else if (m_cnt[i] + 1 >= TOUT) begin
                  m_st[i] = 0; setm[i] = 1'b1;
               end else if (echo_valid && echo_tag == TG'(i) && !echo_accept && !m_ack[i]) begin
                  m_st[i] = 1;
               end else begin
                  if (echo_valid && echo_tag == TG'(i) && echo_accept) m_ack[i] = 1;
                  m_cnt[i]++;
               end
            end
         end
         if (p >= 0 && tx_ready) begin
            m_st[p] = 2; m_cnt[p] = 0; m_ack[p] = 0;
         end
         if (f >= 0 && req_valid) begin
            m_st[f] = 1; m_dat[f] = req_data;
         end
         m_irq = (m_irq & ~(irq_clr_we ? irq_clr_mask : '0)) | setm;
      end
   end

   task automatic cmp_model();
      bit e_ready, e_tx;
      int p;
      e_ready = 0; e_tx = 0; p = 0;
      for (int i = NS - 1; i >= 0; i--) begin
         if (m_st[i] == 0) e_ready = 1;
         if (m_st[i] == 1) begin e_tx = 1; p = i; end
      end
      chk(req_ready == e_ready, "R3 req_ready", 64'(req_ready), 64'(e_ready));
      chk(tx_valid == e_tx, "R2 tx_valid", 64'(tx_valid), 64'(e_tx));
      if (e_tx) begin
         chk(tx_tag == TG'(p), "R2 tx_tag", 64'(tx_tag), 64'(p));
         chk(tx_data == m_dat[p], "R2 tx_data", tx_data[63:0], m_dat[p][63:0]);
      end
      chk(done_valid == m_dv, "R4 done_valid", 64'(done_valid), 64'(m_dv));
      if (m_dv) chk(done_tag == TG'(m_dt), "R10 done_tag", 64'(done_tag), 64'(m_dt));
      chk(irq_status == m_irq, "R5 irq_status", 64'(irq_status), 64'(m_irq));
      chk(stray_count == CW'(m_stray), "R8 stray_count", 64'(stray_count), 64'(m_stray));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_model();
      req_valid = 1'b0; echo_valid = 1'b0; rsp_valid = 1'b0; irq_clr_we = 1'b0;
   endtask

   task automatic send_req(input int n);
      req_valid = 1'b1; req_data = mk(n);
   endtask

   task automatic clear_all();
      irq_clr_we = 1'b1; irq_clr_mask = '1;
      step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
      chk(tx_valid == 1'b0, "R1 tx_valid", 64'(tx_valid), 64'd0);
      chk(irq_status == '0, "R1 irq_status", 64'(irq_status), 64'd0);
      chk(stray_count == '0, "R1 stray_count", 64'(stray_count), 64'd0);
      chk(done_valid == 1'b0, "R1 done_valid", 64'(done_valid), 64'd0);

      // R2 / R4: allocate, send, complete
      send_req(1); step();
      chk(tx_valid && tx_tag == 0, "R2 offered tag", 64'(tx_tag), 64'd0);
      chk(tx_data == mk(1), "R2 offered data", tx_data[63:0], mk(1)[63:0]);
      step();
      rsp_valid = 1'b1; rsp_tag = 0; step();
      chk(done_valid && done_tag == 0, "R4 completion", 64'(done_tag), 64'd0);

      // R5 / R9: timeout then sticky and clear
      send_req(2); step(); step();
      repeat (TOUT - 1) step();
      chk(irq_status == '0, "R5 before deadline", 64'(irq_status), 64'd0);
      step();
      chk(irq_status == 16'h0001, "R5 timeout flag", 64'(irq_status), 64'h1);
      step();
      chk(irq_status == 16'h0001, "R9 sticky", 64'(irq_status), 64'h1);
      clear_all();
      chk(irq_status == '0, "R9 cleared", 64'(irq_status), 64'd0);

      // R6: rejection resends and restarts the timer
      send_req(3); step(); step();
      echo_valid = 1'b1; echo_tag = 0; echo_accept = 1'b0; step();
      chk(tx_valid && tx_tag == 0 && tx_data == mk(3), "R6 resend", tx_data[63:0], mk(3)[63:0]);
      step();
      repeat (TOUT - 1) step();
      chk(irq_status == '0, "R6 timer restarted", 64'(irq_status), 64'd0);
      step();
      chk(irq_status == 16'h0001, "R6 timeout after resend", 64'(irq_status), 64'h1);
      clear_all();

      // R7: acceptance blocks later resends
      send_req(4); step(); step();
      echo_valid = 1'b1; echo_tag = 0; echo_accept = 1'b1; step();
      echo_valid = 1'b1; echo_tag = 0; echo_accept = 1'b0; step();
      chk(tx_valid == 1'b0, "R7 no resend", 64'(tx_valid), 64'd0);
      rsp_valid = 1'b1; rsp_tag = 0; step();
      chk(done_valid && done_tag == 0, "R7 response awaited", 64'(done_valid), 64'd1);

      // R3 / R10: fill the pool, out-of-order completions
      tx_ready = 1'b0;
      for (int k = 0; k < NS; k++) begin
         send_req(10 + k); step();
      end
      chk(req_ready == 1'b0, "R3 full", 64'(req_ready), 64'd0);
      chk(tx_valid && tx_tag == 0, "R2 lowest first", 64'(tx_tag), 64'd0);
      tx_ready = 1'b1;
      repeat (NS) step();
      rsp_valid = 1'b1; rsp_tag = 9; step();
      chk(done_valid && done_tag == 9, "R10 first done", 64'(done_tag), 64'd9);
      chk(req_ready == 1'b1, "R3 ready after release", 64'(req_ready), 64'd1);
      rsp_valid = 1'b1; rsp_tag = 3; step();
      chk(done_valid && done_tag == 3, "R10 second done", 64'(done_tag), 64'd3);
      rsp_valid = 1'b1; rsp_tag = 12; step();
      chk(done_valid && done_tag == 12, "R10 third done", 64'(done_tag), 64'd12);
      repeat (TOUT + 5) step();
      chk(irq_status == 16'hEDF7, "R5 remaining timeouts", 64'(irq_status), 64'hEDF7);
      clear_all();
      chk(irq_status == '0, "R9 full clear", 64'(irq_status), 64'd0);

      // R8: strays, both in one cycle, then saturation
      echo_valid = 1'b1; echo_tag = 5; echo_accept = 1'b1;
      rsp_valid = 1'b1; rsp_tag = 5; step();
      chk(stray_count == 2, "R8 two strays", 64'(stray_count), 64'd2);
      chk(tx_valid == 1'b0 && done_valid == 1'b0, "R8 no effect", 64'(tx_valid), 64'd0);
      for (int k = 0; k < 20; k++) begin
         rsp_valid = 1'b1; rsp_tag = 7; step();
      end
      chk(stray_count == 4'hF, "R8 saturation", 64'(stray_count), 64'hF);
      chk(irq_status == '0, "R8 irq untouched", 64'(irq_status), 64'd0);

      // R11: response on the deadline edge wins
      send_req(40); step(); step();
      repeat (TOUT - 1) step();
      rsp_valid = 1'b1; rsp_tag = 0; step();
      chk(done_valid && done_tag == 0, "R11 completion", 64'(done_valid), 64'd1);
      chk(irq_status == '0, "R11 no flag", 64'(irq_status), 64'd0);

      // R9: set beats clear in the same cycle
      send_req(41); step(); step();
      repeat (TOUT - 1) step();
      irq_clr_we = 1'b1; irq_clr_mask = '1; step();
      chk(irq_status[0] == 1'b1, "R9 set over clear", 64'(irq_status), 64'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule